// File: doc/BRIEF.md
# Step-Loss Detection Counter Pair

This block watches a stepper axis for lost steps. It keeps two signed position counts side by side. The first count follows the step pulses the controller sends to the motor driver, moving up or down with the commanded direction. The second count follows the incremental encoder mounted on the motor shaft. It decodes the A/B quadrature pair at four counts per cycle. A lost step shows up as a gap between the two counts, and that gap is the only criterion the block uses.

Both counts are frozen into a pair of snapshot registers on the same clock edge. The snapshot is taken either on a host request or when a programmable interval timer expires. The timer form covers checking while the axis moves. The host form covers a one-off check once the axis has stopped. One cycle after each snapshot, the block forms the magnitude of the difference between the two snapshots and compares it with a tolerance. If the magnitude is larger, a sticky interrupt is raised, and it stays up until the host clears it.

Top module: `step_loss_monitor`

## Requirements
- R1: Each cycle with `step_i` high changes the command count by one at the next clock edge: +1 when `dir_i` is 1, -1 when `dir_i` is 0. The count wraps modulo 2^CW. A cycle with `step_i` low leaves it unchanged.
- R2: The encoder count moves by one on every single-bit change of the synchronized {A,B} pair, giving four counts per cycle. The sequence {A,B} = 00, 10, 11, 01, 00 (A leading) counts up. The reverse sequence counts down.
- R3: A change of the {A,B} pair in which both bits toggle at once leaves the encoder count unchanged. The new pair becomes the reference for the next change.
- R4: A snapshot request captures the command count and the encoder count from the same edge. Both appear on `cmd_lat_o` and `fb_lat_o` after that edge. A step pulse in the same cycle as the request is not in the snapshot, but it is in the next snapshot.
- R5: One edge after a snapshot, `diff_mag_o` holds |cmd − fb|. The difference is taken as a CW-bit two's-complement value, so either ordering of the two counts gives a positive magnitude.
- R6: The interrupt is set when the magnitude exceeds `tol_i`. A magnitude equal to or below the tolerance does not set it.
- R7: With `period_en_i` high and `period_i` = N ≥ 1, a snapshot and compare happen every N cycles. The first snapshot is taken at the Nth edge with the enable high. With `period_i` = 0 or the enable low, no timed snapshot happens.
- R8: `irq_o` stays high until a cycle with `irq_clr_i` high. It is low after that edge. If a set and a clear fall on the same edge, the set wins.
- R9: After synchronous reset, both counts, both snapshots, the magnitude and the interrupt are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Step pulse strobe, one count per high cycle |
| dir_i | input | 1 | Commanded direction: 1 forward, 0 reverse |
| enc_a_i | input | 1 | Encoder phase A (asynchronous) |
| enc_b_i | input | 1 | Encoder phase B (asynchronous) |
| latch_i | input | 1 | Host snapshot and compare request |
| period_en_i | input | 1 | Enables timed checks |
| period_i | input | TW | Check interval in clock cycles, 0 disables |
| tol_i | input | CW | Allowed magnitude of mismatch |
| irq_clr_i | input | 1 | Clears the sticky interrupt |
| cmd_lat_o | output | CW | Snapshot of the command count |
| fb_lat_o | output | CW | Snapshot of the encoder count |
| diff_mag_o | output | CW | Magnitude of the snapshot difference |
| irq_o | output | 1 | Sticky mismatch interrupt |

## Verification
Each result has a fixed number of edges before it is due:
- A step pulse reaches the command count at the next edge.
- An encoder change reaches the encoder count after SYNC_STAGES + 1 edges.
- A snapshot is visible one edge after the request.
- The magnitude and the interrupt are visible two edges after the request.
- A timed check first shows on the interrupt at edge N + 1 after the enable.

The bench drives inputs and samples outputs on falling edges. Its tasks wait exactly these edge counts before sampling, and in the timed test they also sample one edge early to show the interrupt is not raised ahead of time. Every expected count comes from a bench-side model of the step and quadrature sequences it applies.

// File: rtl/step_loss_pkg.sv
package step_loss_pkg;

  // Classification of one sampled change on the encoder pair {A,B}
  typedef enum logic [1:0] {
    QS_HOLD = 2'd0,
    QS_UP   = 2'd1,
    QS_DOWN = 2'd2,
    QS_BAD  = 2'd3
  } quad_step_e;

  // {A,B}: 00 -> 10 -> 11 -> 01 is forward (A leads B)
  function automatic quad_step_e quad_classify(input logic [1:0] prev_ab,
                                               input logic [1:0] cur_ab);
    logic [1:0] chg;
    chg = prev_ab ^ cur_ab;
    if (chg == 2'b00)                 return QS_HOLD;
    else if (chg == 2'b11)            return QS_BAD;
    else if (cur_ab[1] ^ prev_ab[0])  return QS_UP;
    else                              return QS_DOWN;
  endfunction

endpackage

// File: rtl/sl_cmd_counter.sv
module sl_cmd_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic          dir_i,
  output logic [CW-1:0] count_o
);

  always_ff @(posedge clk) begin
    if (rst)          count_o <= '0;
    else if (step_i)  count_o <= dir_i ? count_o + 1'b1 : count_o - 1'b1;
  end

  assert_cmd_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(count_o));

  assert_cmd_fwd_R1: assert property (@(posedge clk) disable iff (rst)
    (step_i && dir_i) |=> (count_o == $past(count_o) + 1'b1));

  assert_cmd_reset_R9: assert property (@(posedge clk)
    rst |=> (count_o == '0));

endmodule

// File: rtl/sl_quad_counter.sv
module sl_quad_counter
  import step_loss_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enc_a_i,
  input  logic          enc_b_i,
  output logic [CW-1:0] count_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [1:0] sync_q [SYNC_STAGES];
  logic [1:0] prev_q;
  quad_step_e q_step;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 2'b00;
          else     sync_q[g] <= {enc_a_i, enc_b_i};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 2'b00;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_comb q_step = quad_classify(prev_q, sync_q[LAST]);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 2'b00;
      count_o <= '0;
    end else begin
      prev_q <= sync_q[LAST];
      unique case (q_step)
        QS_UP:   count_o <= count_o + 1'b1;
        QS_DOWN: count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  assert_quad_bad_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (q_step == QS_BAD) |=> $stable(count_o));

  assert_quad_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    (q_step == QS_UP) |=> (count_o == $past(count_o) + 1'b1));

  assert_quad_reset_R9: assert property (@(posedge clk)
    rst |=> (count_o == '0));

endmodule

// File: rtl/sl_check_timer.sv
module sl_check_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic [TW-1:0] period_i,
  output logic          expire_o
);

  logic [TW-1:0] tick_q;
  logic          armed;

  always_comb begin
    armed    = en_i && (period_i != '0);
    expire_o = armed && (tick_q >= period_i - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || !armed)  tick_q <= '0;
    else if (expire_o)  tick_q <= '0;
    else                tick_q <= tick_q + 1'b1;
  end

  assert_timer_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    (expire_o && period_i > 1) |=> (!expire_o || !$stable(period_i)));

  assert_timer_off_R7: assert property (@(posedge clk) disable iff (rst)
    (period_i == '0) |-> !expire_o);

endmodule

// File: rtl/sl_latch_compare.sv
module sl_latch_compare #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          latch_i,
  input  logic [CW-1:0] cmd_i,
  input  logic [CW-1:0] fb_i,
  input  logic [CW-1:0] tol_i,
  input  logic          clr_i,
  output logic [CW-1:0] cmd_lat_o,
  output logic [CW-1:0] fb_lat_o,
  output logic [CW-1:0] mag_o,
  output logic          irq_o
);

  logic          cmp_pend;
  logic [CW-1:0] diff;
  logic [CW-1:0] mag_n;
  logic          over;

  always_comb begin
    diff  = cmd_lat_o - fb_lat_o;
    mag_n = diff[CW-1] ? (~diff + 1'b1) : diff;
    over  = cmp_pend && (mag_n > tol_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_lat_o <= '0;
      fb_lat_o  <= '0;
      cmp_pend  <= 1'b0;
      mag_o     <= '0;
      irq_o     <= 1'b0;
    end else begin
      cmp_pend <= latch_i;
      if (latch_i) begin
        cmd_lat_o <= cmd_i;
        fb_lat_o  <= fb_i;
      end
      if (cmp_pend) mag_o <= mag_n;
      irq_o <= over | (irq_o & ~clr_i);
    end
  end

  assert_latch_pair_R4: assert property (@(posedge clk) disable iff (rst)
    latch_i |=> (cmd_lat_o == $past(cmd_i) && fb_lat_o == $past(fb_i)));

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !clr_i) |=> irq_o);

  assert_irq_needs_check_R6: assert property (@(posedge clk) disable iff (rst)
    (!cmp_pend && !irq_o) |=> !irq_o);

  assert_irq_reset_R9: assert property (@(posedge clk)
    rst |=> (!irq_o && mag_o == '0));

endmodule

// File: rtl/step_loss_monitor.sv
module step_loss_monitor #(
  parameter int CW          = 16,
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic          dir_i,
  input  logic          enc_a_i,
  input  logic          enc_b_i,
  input  logic          latch_i,
  input  logic          period_en_i,
  input  logic [TW-1:0] period_i,
  input  logic [CW-1:0] tol_i,
  input  logic          irq_clr_i,
  output logic [CW-1:0] cmd_lat_o,
  output logic [CW-1:0] fb_lat_o,
  output logic [CW-1:0] diff_mag_o,
  output logic          irq_o
);

  logic [CW-1:0] cmd_cnt;
  logic [CW-1:0] fb_cnt;
  logic          timer_hit;
  logic          snap;

  sl_cmd_counter #(.CW(CW)) u_cmd (
    .clk     (clk),
    .rst     (rst),
    .step_i  (step_i),
    .dir_i   (dir_i),
    .count_o (cmd_cnt)
  );

  sl_quad_counter #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) u_fb (
    .clk     (clk),
    .rst     (rst),
    .enc_a_i (enc_a_i),
    .enc_b_i (enc_b_i),
    .count_o (fb_cnt)
  );

  sl_check_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .en_i     (period_en_i),
    .period_i (period_i),
    .expire_o (timer_hit)
  );

  always_comb snap = latch_i | timer_hit;

  sl_latch_compare #(.CW(CW)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .latch_i   (snap),
    .cmd_i     (cmd_cnt),
    .fb_i      (fb_cnt),
    .tol_i     (tol_i),
    .clr_i     (irq_clr_i),
    .cmd_lat_o (cmd_lat_o),
    .fb_lat_o  (fb_lat_o),
    .mag_o     (diff_mag_o),
    .irq_o     (irq_o)
  );

endmodule

// File: tb/test_step_loss_monitor.sv
`timescale 1ns/1ps
module test_step_loss_monitor;

  localparam int CW = 16;
  localparam int TW = 16;
  localparam int SYNC = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          step_i = 1'b0, dir_i = 1'b1;
  logic          enc_a_i = 1'b0, enc_b_i = 1'b0;
  logic          latch_i = 1'b0, period_en_i = 1'b0, irq_clr_i = 1'b0;
  logic [TW-1:0] period_i = '0;
  logic [CW-1:0] tol_i = '0;
  logic [CW-1:0] cmd_lat_o, fb_lat_o, diff_mag_o;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;
  logic [CW-1:0] exp_cmd = '0;
  logic [CW-1:0] exp_fb  = '0;
  int phase = 0;  // index into {A,B} sequence 00,10,11,01

  always #2 clk = ~clk;  // 250 MHz

  step_loss_monitor #(.CW(CW), .TW(TW), .SYNC_STAGES(SYNC)) i_step_loss_monitor (
    .clk(clk), .rst(rst), .step_i(step_i), .dir_i(dir_i),
    .enc_a_i(enc_a_i), .enc_b_i(enc_b_i), .latch_i(latch_i),
    .period_en_i(period_en_i), .period_i(period_i), .tol_i(tol_i),
    .irq_clr_i(irq_clr_i), .cmd_lat_o(cmd_lat_o), .fb_lat_o(fb_lat_o),
    .diff_mag_o(diff_mag_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [1:0] ab_of(input int p);
    case (p & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic logic [CW-1:0] mag(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW-1:0] d;
    d = a - b;
    return d[CW-1] ? -d : d;
  endfunction

  task automatic steps(input logic dir, input int n);
    for (int i = 0; i < n; i++) begin
      step_i = 1'b1; dir_i = dir;
      cyc(1);
      step_i = 1'b0;
      exp_cmd = dir ? exp_cmd + 1'b1 : exp_cmd - 1'b1;
      cyc(1);
    end
  endtask

  task automatic enc_move(input logic up, input int n);
    for (int i = 0; i < n; i++) begin
      phase = up ? phase + 1 : phase + 3;
      {enc_a_i, enc_b_i} = ab_of(phase);
      exp_fb = up ? exp_fb + 1'b1 : exp_fb - 1'b1;
      cyc(SYNC + 2);
    end
  endtask

  // Host snapshot; checks latched pair, magnitude and interrupt
  task automatic snap_check(input string req, input logic exp_irq);
    latch_i = 1'b1;
    cyc(1);
    latch_i = 1'b0;
    chk({req, " cmd snapshot R4"}, cmd_lat_o, exp_cmd);
    chk({req, " fb snapshot R4"}, fb_lat_o, exp_fb);
    cyc(1);
    chk({req, " magnitude R5"}, diff_mag_o, mag(exp_cmd, exp_fb));
    chk({req, " irq R6"}, irq_o, exp_irq);
  endtask

  task automatic clear_irq();
    irq_clr_i = 1'b1;
    cyc(1);
    irq_clr_i = 1'b0;
    chk("clear R8", irq_o, 1'b0);
  endtask

  task automatic t_reset();
    chk("reset cmd R9", cmd_lat_o, 0);
    chk("reset fb R9", fb_lat_o, 0);
    chk("reset mag R9", diff_mag_o, 0);
    chk("reset irq R9", irq_o, 0);
    tol_i = 16'd100;
    snap_check("reset counts R9", 1'b0);
  endtask

  task automatic t_cmd_count();
    steps(1'b1, 5);
    steps(1'b0, 2);
    snap_check("cmd up/down R1", 1'b0);
    steps(1'b0, 6);  // wraps below zero
    snap_check("cmd wrap R1", 1'b0);
  endtask

  task automatic t_quad();
    enc_move(1'b1, 6);
    snap_check("quad forward R2", 1'b0);
    enc_move(1'b0, 9);
    snap_check("quad reverse R2", 1'b0);
  endtask

  task automatic t_bad();
    // jump two phases at once: both bits toggle
    phase = phase + 2;
    {enc_a_i, enc_b_i} = ab_of(phase);
    cyc(SYNC + 3);
    snap_check("double toggle ignored R3", 1'b0);
    enc_move(1'b1, 2);
    snap_check("after double toggle R3", 1'b0);
  endtask

  task automatic t_same_edge();
    step_i = 1'b1; dir_i = 1'b1; latch_i = 1'b1;
    cyc(1);
    step_i = 1'b0; latch_i = 1'b0;
    chk("same-edge excludes pulse R4", cmd_lat_o, exp_cmd);
    exp_cmd = exp_cmd + 1'b1;
    cyc(1);
    snap_check("next snapshot includes pulse R4", 1'b0);
  endtask

  task automatic t_tolerance();
    logic [CW-1:0] m;
    m = mag(exp_cmd, exp_fb);
    tol_i = m;
    snap_check("equal tolerance R6", 1'b0);
    tol_i = m - 1'b1;
    snap_check("exceeded tolerance R6", 1'b1);
    tol_i = 16'd100;
    cyc(5);
    chk("sticky irq R8", irq_o, 1'b1);
    clear_irq();
    // set and clear on the same edge: set wins
    tol_i = 16'd0;
    latch_i = 1'b1;
    cyc(1);
    latch_i = 1'b0;
    irq_clr_i = 1'b1;
    cyc(1);
    irq_clr_i = 1'b0;
    chk("set beats clear R8", irq_o, 1'b1);
    clear_irq();
  endtask

  task automatic t_periodic();
    tol_i = 16'd0;
    period_i = 16'd7;
    period_en_i = 1'b1;
    cyc(7);
    chk("no early timed check R7", irq_o, 1'b0);
    cyc(1);
    chk("timed check fires R7", irq_o, 1'b1);
    chk("timed magnitude R7", diff_mag_o, mag(exp_cmd, exp_fb));
    period_en_i = 1'b0;
    cyc(1);
    clear_irq();
    period_i = 16'd0;
    period_en_i = 1'b1;
    cyc(20);
    chk("zero period no check R7", irq_o, 1'b0);
    period_en_i = 1'b0;
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_cmd_count();
    t_quad();
    t_bad();
    t_same_edge();
    t_tolerance();
    t_periodic();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule